// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer. It is clocked by the output of an external dual-modulus prescaler, whose moduli are P and P+1. It steers that prescaler through a modulus-select output and issues one divided pulse per output cycle. A swallow count A and a program count B set the total ratio N = P·B + A. Each output cycle lasts B prescaler output cycles. During the first A of them the prescaler divides by P+1, and during the remaining B−A it divides by P. The total is therefore A·(P+1) + (B−A)·P = N input cycles.

A build parameter selects one of two configurations. In the wide one, A takes the low 5 bits of the 16-bit ratio word, B takes the upper 11 bits, and P is 32. In the narrow one, A takes the low 4 bits, B takes the upper 12 bits, and P is 16. A written ratio is checked first and then parked in a holding register. The counters take it over only at an output-cycle boundary. A ratio below the continuous-range floor, or one with B < A, is refused, and the divider keeps running with its previous ratio.

Top module: `pulse_swallow_div`

## Requirements
- R1: A written 16-bit ratio word splits into A (low 5 bits when WIDE_PRESCALER=1, low 4 bits when 0) and B (all remaining upper bits), with P = 32 or 16 respectively.
- R2: Every output cycle spans exactly B clock cycles, and div_out is high only in the last clock of it, for one cycle.
- R3: mod_sel is high (select P+1) for the first A clocks of an output cycle and low for the remaining B−A clocks. The weighted length A·(P+1)+(B−A)·P therefore equals N.
- R4: A write whose word is below the floor (992 wide, 240 narrow) or has B < A is refused. cfg_err is high from the next clock, and the running ratio is unchanged.
- R5: An accepted write clears cfg_err from the next clock.
- R6: An accepted ratio takes effect at the first output-cycle boundary after it is registered. The cycle in progress completes with the old ratio.
- R7: When several accepted writes land before one boundary, the last one is applied.
- R8: After reset, cfg_err and mod_sel are low and the ratio equals the floor value (A = 0). The first output cycle lasts the floor's B, counting the clock in which reset is released.
- R9: With A = B, mod_sel stays high for the whole output cycle. With A = 0, it never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output, used as the block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Ratio write strobe, one clock per write |
| cfg_n | input | 16 | Ratio word N written with cfg_we |
| mod_sel | output | 1 | Prescaler modulus select: 1 = P+1, 0 = P |
| div_out | output | 1 | One-clock divided output pulse at the end of each output cycle |
| cfg_err | output | 1 | High after a refused write, cleared by an accepted one |

## Verification
The bench measures output cycles at the pins. It takes the cycle length from div_out and the swallow count from mod_sel, and checks that the two recombine into the written N. This catches a divider that is off by one in either counter or splits the word at the wrong bit. The extremes A = 0, A = B, the floor value and the full 16-bit maximum are all driven. A swallow counter that wraps or fails to stop would show here as a wrong count or as a second high stretch of mod_sel. Directed cases write in the middle of an output cycle, write twice before one boundary, and follow a good write with a bad one. A design that reloads immediately would shorten the running cycle, and one that keeps the first write would show the wrong ratio. One that lets a refused word overwrite the holding register would lose the good value.

// File: rtl/psd_pkg.sv
package psd_pkg;

    localparam int NW   = 16;
    localparam int AMAX = 5;
    localparam int BMAX = 12;

    typedef struct packed {
        logic [BMAX-1:0] b;
        logic [AMAX-1:0] a;
    } ratio_t;

    typedef enum logic [1:0] {
        WR_IDLE   = 2'd0,
        WR_TAKEN  = 2'd1,
        WR_REJECT = 2'd2
    } wr_res_e;

    function automatic int a_bits(bit wide);
        return wide ? 5 : 4;
    endfunction

    function automatic int p_mod(bit wide);
        return wide ? 32 : 16;
    endfunction

    function automatic int n_floor(bit wide);
        return wide ? 992 : 240;
    endfunction

    function automatic ratio_t split_n(logic [NW-1:0] n, bit wide);
        ratio_t r;
        if (wide) begin
            r.a = n[4:0];
            r.b = {1'b0, n[15:5]};
        end else begin
            r.a = {1'b0, n[3:0]};
            r.b = n[15:4];
        end
        return r;
    endfunction

endpackage

// File: rtl/psd_ratio_gate.sv
module psd_ratio_gate
    import psd_pkg::*;
#(
    parameter bit WIDE_PRESCALER = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [NW-1:0] wr_n,
    input  logic          consume,
    output ratio_t        pend_o,
    output logic          pend_vld_o,
    output logic          err_o
);

    localparam logic [NW-1:0] NMIN = NW'(n_floor(WIDE_PRESCALER));

    ratio_t  cand;
    wr_res_e res;
    ratio_t  pend_q;
    logic    vld_q;
    logic    err_q;

    always_comb begin
        cand = split_n(wr_n, WIDE_PRESCALER);
        if (!wr_en) begin
            res = WR_IDLE;
        end else if ((wr_n >= NMIN) &&
                     (cand.b >= {{(BMAX-AMAX){1'b0}}, cand.a})) begin
            res = WR_TAKEN;
        end else begin
            res = WR_REJECT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= split_n(NMIN, WIDE_PRESCALER);
            vld_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (consume) begin
                vld_q <= 1'b0;
            end
            case (res)
                WR_TAKEN: begin
                    pend_q <= cand;
                    vld_q  <= 1'b1;
                    err_q  <= 1'b0;
                end
                WR_REJECT: begin
                    err_q  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign pend_o     = pend_q;
    assign pend_vld_o = vld_q;
    assign err_o      = err_q;

endmodule

// File: rtl/psd_prog_ctr.sv
module psd_prog_ctr
    import psd_pkg::*;
#(
    parameter int unsigned RST_B = 31
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [BMAX-1:0] reload_b,
    output logic            term_o
);

    logic [BMAX-1:0] rem_q;

    assign term_o = (rem_q == BMAX'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= BMAX'(RST_B);
        end else if (term_o) begin
            rem_q <= reload_b;
        end else begin
            rem_q <= rem_q - BMAX'(1);
        end
    end

endmodule

// File: rtl/psd_swallow_ctr.sv
module psd_swallow_ctr
    import psd_pkg::*;
#(
    parameter int unsigned RST_A = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            term_i,
    input  logic [AMAX-1:0] reload_a,
    output logic            swallow_o
);

    logic [AMAX-1:0] rem_q;

    assign swallow_o = (rem_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= AMAX'(RST_A);
        end else if (term_i) begin
            rem_q <= reload_a;
        end else if (swallow_o) begin
            rem_q <= rem_q - AMAX'(1);
        end
    end

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
    import psd_pkg::*;
#(
    parameter bit WIDE_PRESCALER = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [NW-1:0] cfg_n,
    output logic          mod_sel,
    output logic          div_out,
    output logic          cfg_err
);

    localparam logic [NW-1:0] NMIN  = NW'(n_floor(WIDE_PRESCALER));
    localparam ratio_t        DEF_R = split_n(NMIN, WIDE_PRESCALER);

    ratio_t pend;
    logic   pend_vld;
    ratio_t act_q;
    ratio_t reload;
    logic   term;

    psd_ratio_gate #(.WIDE_PRESCALER(WIDE_PRESCALER)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cfg_we),
        .wr_n       (cfg_n),
        .consume    (term),
        .pend_o     (pend),
        .pend_vld_o (pend_vld),
        .err_o      (cfg_err)
    );

    assign reload = pend_vld ? pend : act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= DEF_R;
        end else if (term) begin
            act_q <= reload;
        end
    end

    psd_prog_ctr #(.RST_B(int'(DEF_R.b))) u_bctr (
        .clk      (clk),
        .rst      (rst),
        .reload_b (reload.b),
        .term_o   (term)
    );

    psd_swallow_ctr #(.RST_A(int'(DEF_R.a))) u_actr (
        .clk       (clk),
        .rst       (rst),
        .term_i    (term),
        .reload_a  (reload.a),
        .swallow_o (mod_sel)
    );

    assign div_out = term;

endmodule

// File: rtl/pulse_swallow_div_chk.sv
module pulse_swallow_div_chk
    import psd_pkg::*;
#(
    parameter bit WIDE_PRESCALER = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_we,
    input logic [NW-1:0] cfg_n,
    input logic          mod_sel,
    input logic          div_out,
    input logic          cfg_err,
    input ratio_t        act_ratio
);

    localparam logic [NW-1:0] NMIN = NW'(n_floor(WIDE_PRESCALER));

    logic [BMAX:0] cyc_q;
    logic [BMAX:0] sw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= (BMAX+1)'(1);
            sw_q  <= '0;
        end else if (div_out) begin
            cyc_q <= (BMAX+1)'(1);
            sw_q  <= '0;
        end else begin
            cyc_q <= cyc_q + (BMAX+1)'(1);
            sw_q  <= sw_q + (BMAX+1)'(mod_sel);
        end
    end

    // R2
    cyc_len_chk: assert property (@(posedge clk) disable iff (rst)
        div_out |-> (cyc_q == {1'b0, act_ratio.b}));

    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        div_out |=> !div_out);

    // R3
    swallow_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        div_out |-> ((sw_q + (BMAX+1)'(mod_sel)) == (BMAX+1)'(act_ratio.a)));

    // R3
    mod_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mod_sel) |-> $past(div_out));

    // R4
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (cfg_n < NMIN)) |=> cfg_err);

    // R5
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (cfg_n >= NMIN) &&
         (split_n(cfg_n, WIDE_PRESCALER).b >= {{(BMAX-AMAX){1'b0}}, split_n(cfg_n, WIDE_PRESCALER).a}))
        |=> !cfg_err);

    // R6
    ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !div_out |=> $stable(act_ratio));

endmodule

bind pulse_swallow_div pulse_swallow_div_chk #(.WIDE_PRESCALER(WIDE_PRESCALER)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_n     (cfg_n),
    .mod_sel   (mod_sel),
    .div_out   (div_out),
    .cfg_err   (cfg_err),
    .act_ratio (act_q)
);

// File: tb/test_pulse_swallow_div.sv
module test_pulse_swallow_div;

    localparam int TB_AW   = 5;
    localparam int TB_P    = 32;
    localparam int TB_NMIN = 992;
    localparam int NVEC    = 10;

    // bit 16 = write is expected to be refused
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 16'd992},   // floor, A=0
        {1'b0, 16'd1000},  // B=31 A=8
        {1'b0, 16'd1023},  // A=B=31
        {1'b1, 16'd991},   // below floor
        {1'b0, 16'd4096},  // B=128 A=0
        {1'b1, 16'd0},
        {1'b0, 16'd2047},  // B=63 A=31
        {1'b1, 16'd500},
        {1'b0, 16'd65535}, // maximum
        {1'b0, 16'd1056}   // B=33 A=0
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_n = '0;
    logic        mod_sel;
    logic        div_out;
    logic        cfg_err;

    int n_run  = 0;
    int n_fail = 0;
    int good_n = TB_NMIN;

    always #2.5 clk = ~clk;

    pulse_swallow_div i_pulse_swallow_div (
        .clk     (clk),
        .rst     (rst),
        .cfg_we  (cfg_we),
        .cfg_n   (cfg_n),
        .mod_sel (mod_sel),
        .div_out (div_out),
        .cfg_err (cfg_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_n(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_n  = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic sync_end();
        do @(negedge clk); while (!div_out);
    endtask

    // Counts one whole output cycle starting after the current negedge.
    task automatic measure(output int len, output int acnt, output bit split);
        bit fell = 1'b0;
        len = 0; acnt = 0; split = 1'b0;
        do begin
            @(negedge clk);
            len++;
            if (mod_sel) begin
                acnt++;
                if (fell) split = 1'b1;
            end else begin
                fell = 1'b1;
            end
        end while (!div_out);
    endtask

    task automatic check_cycle(input int n, input string tag);
        int len, acnt, wsum;
        bit split;
        measure(len, acnt, split);
        wsum = acnt * (TB_P + 1) + (len - acnt) * TB_P;
        check(len == (n >> TB_AW), "R2", {tag, " cycle length"}, len, n >> TB_AW);
        check(acnt == (n & ((1 << TB_AW) - 1)), "R1", {tag, " swallow count"},
              acnt, n & ((1 << TB_AW) - 1));
        check(wsum == n, "R3", {tag, " weighted length"}, wsum, n);
        check(!split, "R3", {tag, " mod_sel contiguous"}, int'(split), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int len, acnt, cnt;
        bit split;
        int nv;
        bit bad;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: state right after reset release
        check(cfg_err == 1'b0, "R8", "cfg_err after reset", int'(cfg_err), 0);
        check(mod_sel == 1'b0, "R8", "mod_sel after reset", int'(mod_sel), 0);
        check(div_out == 1'b0, "R8", "div_out after reset", int'(div_out), 0);
        measure(len, acnt, split);
        check(len + 1 == TB_NMIN >> TB_AW, "R8", "first cycle length",
              len + 1, TB_NMIN >> TB_AW);
        check(acnt == 0, "R8", "first cycle swallow", acnt, 0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            bad = VEC[i][16];
            nv  = int'(VEC[i][15:0]);
            write_n(VEC[i][15:0]);
            if (bad) begin
                check(cfg_err == 1'b1, "R4", "refused write flag", int'(cfg_err), 1);
            end else begin
                check(cfg_err == 1'b0, "R5", "accepted write flag", int'(cfg_err), 0);
                good_n = nv;
            end
            sync_end();
            // R4 / R9 covered by table entries (refused words, A=B, A=0)
            check_cycle(good_n, "table");
        end

        // R6: write mid-cycle, running cycle keeps old length
        sync_end();
        @(negedge clk);
        cfg_we = 1'b1; cfg_n = 16'd2047;
        cnt = 1;
        @(negedge clk);
        cfg_we = 1'b0;
        cnt++;
        while (!div_out) begin
            @(negedge clk);
            cnt++;
        end
        check(cnt == (good_n >> TB_AW), "R6", "running cycle kept old B",
              cnt, good_n >> TB_AW);
        good_n = 2047;
        check_cycle(good_n, "R6 new ratio");

        // R7: back-to-back writes, last wins
        sync_end();
        @(negedge clk);
        cfg_we = 1'b1; cfg_n = 16'd1000;
        @(negedge clk);
        cfg_n = 16'd1023;
        @(negedge clk);
        cfg_we = 1'b0;
        good_n = 1023;
        sync_end();
        check_cycle(good_n, "R7 last write");

        // R4: good write then refused write before boundary keeps good one
        sync_end();
        write_n(16'd1056);
        write_n(16'd900);
        check(cfg_err == 1'b1, "R4", "refused after accepted", int'(cfg_err), 1);
        good_n = 1056;
        sync_end();
        check_cycle(good_n, "R4 held");

        // R9: A=B keeps mod_sel high across the whole cycle
        write_n(16'd1023);
        sync_end();
        measure(len, acnt, split);
        check(acnt == len, "R9", "A=B mod_sel high count", acnt, len);

        // R9: A=0 never raises mod_sel
        write_n(16'd4096);
        sync_end();
        measure(len, acnt, split);
        check(acnt == 0, "R9", "A=0 mod_sel high count", acnt, 0);

        // R5: accepted write clears a set flag
        write_n(16'd10);
        write_n(16'd1500);
        check(cfg_err == 1'b0, "R5", "flag cleared", int'(cfg_err), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule